// File: doc/BRIEF.md
# Odd-Line Inversion Flit Link Codec

This block sits in a network interface and lowers the coupling switching activity on an inter-router link. Before a body flit goes onto the link, the encoder compares it with the link word it sent last. For every pair of adjacent lines it asks whether complementing the odd-numbered lines of the new flit would lower that pair's weighted coupling cost. If a strict majority of the pairs says yes, the odd lines are complemented and a flag line is raised. Header flits always pass through as they are, and each header restarts the comparison history.

The encoder takes one payload word with a header/body tag through a valid/ready handshake. It registers the link word with one cycle of latency. The decoder is a separate combinational path: it takes a received link word and complements the odd payload lines again whenever the flag line is set. Because the encoding decision is made once per flit at the network interface, every hop of a wormhole path sees the same reduced activity.

Top module: `oic_link_codec`

## Requirements
- R1: A flit accepted with the header tag set appears on the link with its payload unchanged and the flag line (bit LINK_W-1) at 0. Its acceptance clears the comparison history to all zeros.
- R2: A body flit is judged as a LINK_W-bit word made of its payload in bits LINK_W-2..0 and a 0 in the flag position. It is compared against the full previous link word held in the history, flag bit included.
- R3: Each of the LINK_W-1 adjacent line pairs is scored with a coupling cost. The cost is 1 when exactly one line of the pair toggles, 2 when both toggle in opposite directions, and 0 when both toggle the same way or neither toggles. A pair votes for inversion when the cost with the odd payload lines complemented is strictly lower than the cost without.
- R4: Inversion is chosen when twice the vote count exceeds LINK_W-1. A vote count of exactly (LINK_W-1)/2 gives no inversion.
- R5: When inversion is chosen, payload bits 1, 3, 5, ... are complemented and the flag line is 1. Otherwise the payload passes unchanged with the flag at 0.
- R6: The history changes only on an input handshake (inValid and inReady both high). A body flit loads its encoded link word; a header clears the history.
- R7: The link word and outValid appear on the clock edge after the input handshake. inReady equals !outValid || outReady. While outValid is high and outReady is low, the link word holds steady.
- R8: The decoder output rxPayload equals rxWord bits LINK_W-2..0 with bits 1, 3, 5, ... complemented when rxWord bit LINK_W-1 is 1, and unchanged when it is 0. This is combinational.
- R9: During and right after reset, outValid is 0, inReady is 1 and the history is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input flit valid |
| inReady | output | 1 | Encoder can take a flit |
| inIsHeader | input | 1 | Flit is a packet header |
| inPayload | input | LINK_W-1 | Flit payload |
| outValid | output | 1 | Link word valid |
| outReady | input | 1 | Link accepts the word |
| linkWord | output | LINK_W | Encoded link word, flag in the top bit |
| rxWord | input | LINK_W | Received link word for the decoder |
| rxPayload | output | LINK_W-1 | Restored payload |

## Verification
The bench builds the codec with LINK_W = 9: eight payload lines, eight line pairs and a majority threshold of five votes. At that width a single odd-line pattern can land exactly on the four-vote tie, and the flag line's own pair can decide the outcome, so both boundaries can be worked out by hand. The narrow word also lets a random stream with random back-pressure reach inversion, no inversion and header resets many times within a few hundred cycles.

// File: rtl/oic_pkg.sv
package oic_pkg;
  typedef struct packed {
    logic loadOut;
    logic loadHist;
    logic clearHist;
  } ctrlStrobes_t;
endpackage

// File: rtl/oic_ctrl.sv
module oic_ctrl
  import oic_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inIsHeader,
  input  logic         outReady,
  output logic         inReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);
  logic outValidQ;
  logic accept;

  assign inReady  = !outValidQ || outReady;
  assign accept   = inValid && inReady;
  assign outValid = outValidQ;

  always_ff @(posedge clk) begin
    if (!rstN)        outValidQ <= 1'b0;
    else if (inReady) outValidQ <= inValid;
  end

  always_comb begin
    strobes.loadOut   = accept;
    strobes.loadHist  = accept && !inIsHeader;
    strobes.clearHist = accept && inIsHeader;
  end
endmodule

// File: rtl/oic_datapath.sv
module oic_datapath
  import oic_pkg::*;
#(
  parameter int LINK_W = 33
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              inIsHeader,
  input  logic [LINK_W-2:0] inPayload,
  output logic [LINK_W-1:0] linkWord
);
  localparam int PAY_W   = LINK_W - 1;
  localparam int PAIRS   = LINK_W - 1;
  localparam int CNT_W   = $clog2(LINK_W) + 1;

  function automatic logic [LINK_W-1:0] oddMask();
    logic [LINK_W-1:0] m;
    m = '0;
    for (int i = 0; i < PAY_W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  localparam logic [LINK_W-1:0] ODD_MASK = oddMask();

  function automatic logic [1:0] pairCost(input logic pa, input logic pb,
                                          input logic ca, input logic cb);
    logic ta, tb;
    ta = pa ^ ca;
    tb = pb ^ cb;
    if (ta && tb)     return (ca != cb) ? 2'd2 : 2'd0;
    else if (ta || tb) return 2'd1;
    else              return 2'd0;
  endfunction

  logic [LINK_W-1:0] prevWord;
  logic [LINK_W-1:0] curWord;
  logic [LINK_W-1:0] candWord;
  logic [LINK_W-1:0] encWord;
  logic [PAIRS-1:0]  pairVote;
  logic [CNT_W-1:0]  voteCount;
  logic              doInvert;

  assign curWord  = {1'b0, inPayload};
  assign candWord = curWord ^ ODD_MASK;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic [1:0] costPlain;
    logic [1:0] costInv;
    assign costPlain   = pairCost(prevWord[p], prevWord[p+1], curWord[p], curWord[p+1]);
    assign costInv     = pairCost(prevWord[p], prevWord[p+1], candWord[p], candWord[p+1]);
    assign pairVote[p] = costInv < costPlain;
  end

  always_comb begin
    voteCount = '0;
    for (int i = 0; i < PAIRS; i++) voteCount = voteCount + CNT_W'(pairVote[i]);
  end

  assign doInvert = !inIsHeader && ({voteCount, 1'b0} > (CNT_W+1)'(PAIRS));
  assign encWord  = doInvert ? {1'b1, candWord[PAY_W-1:0]} : curWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevWord <= '0;
      linkWord <= '0;
    end else begin
      if (strobes.loadOut)        linkWord <= encWord;
      if (strobes.clearHist)      prevWord <= '0;
      else if (strobes.loadHist)  prevWord <= encWord;
    end
  end
endmodule

// File: rtl/oic_decoder.sv
module oic_decoder #(
  parameter int LINK_W = 33
) (
  input  logic [LINK_W-1:0] rxWord,
  output logic [LINK_W-2:0] rxPayload
);
  localparam int PAY_W = LINK_W - 1;

  logic [PAY_W-1:0] restoreMask;

  for (genvar i = 0; i < PAY_W; i++) begin : g_mask
    assign restoreMask[i] = rxWord[LINK_W-1] && ((i % 2) == 1);
  end

  assign rxPayload = rxWord[PAY_W-1:0] ^ restoreMask;
endmodule

// File: rtl/oic_link_codec.sv
module oic_link_codec
  import oic_pkg::*;
#(
  parameter int LINK_W = 33
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic              inIsHeader,
  input  logic [LINK_W-2:0] inPayload,
  output logic              outValid,
  input  logic              outReady,
  output logic [LINK_W-1:0] linkWord,
  input  logic [LINK_W-1:0] rxWord,
  output logic [LINK_W-2:0] rxPayload
);
  ctrlStrobes_t strobes;

  oic_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inIsHeader(inIsHeader),
    .outReady(outReady), .inReady(inReady), .outValid(outValid), .strobes(strobes)
  );

  oic_datapath #(.LINK_W(LINK_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .inIsHeader(inIsHeader),
    .inPayload(inPayload), .linkWord(linkWord)
  );

  oic_decoder #(.LINK_W(LINK_W)) dec_i (
    .rxWord(rxWord), .rxPayload(rxPayload)
  );
endmodule

// File: rtl/oic_link_codec_chk.sv
module oic_link_codec_chk #(
  parameter int LINK_W = 33
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              inIsHeader,
  input logic [LINK_W-2:0] inPayload,
  input logic              outValid,
  input logic              outReady,
  input logic [LINK_W-1:0] linkWord
);
  logic [LINK_W-2:0] chkMask;
  for (genvar i = 0; i < LINK_W-1; i++) begin : g_m
    assign chkMask[i] = (i % 2) == 1;
  end

  logic [LINK_W-2:0] undone;
  assign undone = linkWord[LINK_W-1] ? (linkWord[LINK_W-2:0] ^ chkMask) : linkWord[LINK_W-2:0];

  // R1: header goes out with flag low
  p_header_plain_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inIsHeader) |=> (linkWord[LINK_W-1] == 1'b0));

  // R5: encoded word always recovers the accepted payload
  p_lossless_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (undone == $past(inPayload)));

  // R7: stalled word is held
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(linkWord)));

  // R7: empty output register always accepts
  p_ready_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  // R7: valid rises only after a handshake
  p_valid_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid && inReady));
endmodule

bind oic_link_codec oic_link_codec_chk #(.LINK_W(LINK_W)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .inIsHeader(inIsHeader), .inPayload(inPayload), .outValid(outValid),
  .outReady(outReady), .linkWord(linkWord)
);

// File: tb/oic_link_codec_tb.sv
module oic_link_codec_tb_top;
  localparam int BW = 9;
  localparam int PW = BW - 1;
  localparam int NVEC = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic          inIsHeader = 1'b0;
  logic [PW-1:0] inPayload = '0;
  logic          outValid;
  logic          outReady = 1'b1;
  logic [BW-1:0] linkWord;
  logic [BW-1:0] rxWord = '0;
  logic [PW-1:0] rxPayload;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  oic_link_codec #(.LINK_W(BW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inIsHeader(inIsHeader), .inPayload(inPayload), .outValid(outValid),
    .outReady(outReady), .linkWord(linkWord), .rxWord(rxWord), .rxPayload(rxPayload)
  );

  // {header, payload, expected link word}
  localparam logic [17:0] VEC [NVEC] = '{
    {1'b0, 8'hAA, 9'h100},  // R3 R5: all odd rises -> invert
    {1'b0, 8'h00, 9'h000},  // R2: flag line of previous counts
    {1'b0, 8'hFF, 9'h0FF},  // R3: same-direction pairs do not vote
    {1'b0, 8'h55, 9'h1FF},  // R5: invert against 0x0FF
    {1'b1, 8'h3C, 9'h03C},  // R1: header plain
    {1'b0, 8'h0A, 9'h00A},  // R4: tie of four votes, no invert
    {1'b1, 8'h00, 9'h000},  // R1
    {1'b0, 8'h2A, 9'h180},  // R4: six votes, invert
    {1'b1, 8'h12, 9'h012},  // R1 R6: clears history
    {1'b0, 8'hAA, 9'h100}   // R6: compared against zero history
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int cost(input bit pa, input bit pb, input bit ca, input bit cb);
    bit ta = pa ^ ca;
    bit tb = pb ^ cb;
    if (ta && tb) return (ca != cb) ? 2 : 0;
    if (ta || tb) return 1;
    return 0;
  endfunction

  function automatic logic [BW-1:0] model(input logic [BW-1:0] prev, input logic [PW-1:0] pay);
    logic [BW-1:0] cur, alt;
    int votes;
    cur = {1'b0, pay};
    alt = cur ^ {1'b0, 8'hAA};
    votes = 0;
    for (int p = 0; p < BW-1; p++)
      if (cost(prev[p], prev[p+1], alt[p], alt[p+1]) < cost(prev[p], prev[p+1], cur[p], cur[p+1]))
        votes++;
    return (2*votes > BW-1) ? {1'b1, alt[PW-1:0]} : cur;
  endfunction

  task automatic sendFlit(input bit hdr, input logic [PW-1:0] pay);
    @(negedge clk);
    inValid = 1'b1; inIsHeader = hdr; inPayload = pay;
    #1;
    while (!inReady) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    finishRun();
  end

  initial begin
    logic [BW-1:0] expQ [$];
    logic [BW-1:0] hist;
    bit pending;

    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R9 outValid in reset", outValid, 0);
    check(inReady == 1'b1, "R9 inReady in reset", inReady, 1);
    @(negedge clk) rstN = 1'b1;

    // table walk, link always ready
    for (int v = 0; v < NVEC; v++) begin
      sendFlit(VEC[v][17], VEC[v][16:9]);
      check(outValid == 1'b1, "R7 valid after accept", outValid, 1);
      check(linkWord == VEC[v][8:0],
            VEC[v][17] ? "R1 header word" : "R5 body word", linkWord, VEC[v][8:0]);
      rxWord = linkWord; #1;
      check(rxPayload == VEC[v][16:9], "R8 decode round trip", rxPayload, VEC[v][16:9]);
    end

    // decoder directed cases
    rxWord = 9'h1FF; #1;
    check(rxPayload == 8'h55, "R8 flag set restores", rxPayload, 8'h55);
    rxWord = 9'h0FF; #1;
    check(rxPayload == 8'hFF, "R8 flag clear passes", rxPayload, 8'hFF);

    // stall: output held, history not updated by unaccepted flit
    @(negedge clk) outReady = 1'b0;
    sendFlit(1'b1, 8'h11);
    @(negedge clk);
    inValid = 1'b1; inIsHeader = 1'b0; inPayload = 8'h22;
    repeat (3) @(negedge clk);
    #1;
    check(inReady == 1'b0, "R7 not ready while stalled", inReady, 0);
    check(linkWord == 9'h011, "R7 word held while stalled", linkWord, 9'h011);
    outReady = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    check(linkWord == model('0, 8'h22), "R6 body after stalled header", linkWord, model('0, 8'h22));

    // random stream with back-pressure
    hist = model('0, 8'h22);
    pending = 1'b0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      outReady = ($urandom % 4) != 0;
      if (!pending && ($urandom % 3) != 0) begin
        pending = 1'b1;
        inValid = 1'b1;
        inIsHeader = ($urandom % 6) == 0;
        inPayload = 8'($urandom);
      end else if (!pending) begin
        inValid = 1'b0;
      end
      #1;
      if (outValid && outReady) begin
        if (expQ.size() == 0)
          check(1'b0, "R7 unexpected word", linkWord, 0);
        else begin
          logic [BW-1:0] e;
          e = expQ.pop_front();
          check(linkWord == e, "R4 R6 stream word", linkWord, e);
        end
      end
      if (inValid && inReady) begin
        if (inIsHeader) begin
          expQ.push_back({1'b0, inPayload});
          hist = '0;
        end else begin
          hist = model(hist, inPayload);
          expQ.push_back(hist);
        end
        pending = 1'b0;
      end
    end
    @(negedge clk) inValid = 1'b0; outReady = 1'b1;
    #1;
    if (outValid && expQ.size() != 0) begin
      logic [BW-1:0] e;
      e = expQ.pop_front();
      check(linkWord == e, "R6 stream last word", linkWord, e);
    end
    finishRun();
  end
endmodule